// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block gathers 32 interrupt request lines and presents them to a processor through two independent register banks. One bank drives the normal interrupt output and the other drives the fast interrupt output. Both banks see the same synchronised input lines. Each bank decides separately, per line, whether the line is enabled, whether it is level or edge sensitive, and which level or edge counts as active.

The raw lines first pass through a two-flop synchroniser. In level mode a line is pending for as long as it sits at its active level. In edge mode the chosen edge sets a sticky latch, and that latch stays set until software writes a one to the line's bit in the bank's clear register. A bank's status view is its enable vector ANDed with its pending vector. The bank's output is high whenever any status bit is set.

Software reaches the block through a plain 32-bit read/write port with byte addresses. Reads are combinational from the address. Writes take effect on the clock edge where the write strobe is high.

Top module: `dual_intc`

## Requirements
- R1: After reset, the enable, trigger-mode and polarity registers and all edge latches are zero. Both outputs are low, and every register reads zero while the input lines are low.
- R2: Address bit 5 selects the bank: 0 is normal and 1 is fast. Address bits 4:2 pick the register: 0 source, 1 enable, 2 clear, 3 mode, 4 polarity, 5 status. Bits 1:0 must be zero. Any other address, and the clear register, read as zero.
- R3: The source register returns each raw line delayed by two clock edges. It is read-only, so a write to it changes nothing.
- R4: The enable, mode and polarity registers read back the value last written to them.
- R5: The status register equals the enable register ANDed with the pending vector. Writing all zeros to the enable register drops that bank's output on the next cycle.
- R6: With mode bit 0 (level), polarity 0 makes the line pending while it is high. Polarity 1 makes it pending while it is low. Nothing is latched.
- R7: With mode bit 1 (edge), polarity 1 latches a rising edge and polarity 0 latches a falling edge. The latch stays set after the line returns to its previous level.
- R8: Writing 1 to a clear bit resets that line's edge latch. Bits written as 0 leave their latches unchanged.
- R9: If a selected edge is detected in the same cycle as a clear write to that bit, the latch remains set.
- R10: Each bank's output is high exactly when its status register is nonzero. The two banks act independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 32 | Raw interrupt request lines, asynchronous |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 6 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| norm_irq | output | 1 | Normal interrupt output |
| fast_irq | output | 1 | Fast interrupt output |

## Verification
The assertions assume that reg_addr and reg_wdata are stable whenever reg_wr is high. They also assume that a line change on the inputs is followed by enough quiet cycles to pass the synchroniser before anything is concluded about it. The bench changes inputs only on falling clock edges. In its random phase it holds the lines steady for several cycles after each change and issues clear and configuration writes only while the lines are steady, so the expected latch state depends only on recorded transitions. The clear-versus-edge collision is the one exception: a directed case places the clear write in the exact cycle the edge is detected.

// File: rtl/intc_pkg.sv
// Shared definitions for the dual-bank interrupt controller.
// Assumes a byte address whose bits 4:2 select a word within a bank.
package intc_pkg;

    // Word index of each register inside a bank
    typedef enum logic [2:0] {
        RIDX_SRC  = 3'd0,
        RIDX_EN   = 3'd1,
        RIDX_CLR  = 3'd2,
        RIDX_MODE = 3'd3,
        RIDX_POL  = 3'd4,
        RIDX_STAT = 3'd5
    } reg_idx_e;

    // Per-bank write strobes decoded from the register port
    typedef struct packed {
        logic en;
        logic clr;
        logic mode;
        logic pol;
    } bank_we_t;

endpackage

// File: rtl/intc_sync.sv
// Multi-stage synchroniser for the raw request lines.
// Produces the synchronised level and a one-cycle delayed copy of it
// for edge detection. Assumes STAGES >= 1.
module intc_sync #(
    parameter int NUM_LINES = 32,
    parameter int STAGES    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] async_i,
    output logic [NUM_LINES-1:0] sync_o,
    output logic [NUM_LINES-1:0] prev_o
);

    logic [NUM_LINES-1:0] chain_q [STAGES];

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_first
                // First capture flop of the synchroniser chain
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_rest
                // Further resolution flops of the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[k] <= '0;
                    else        chain_q[k] <= chain_q[k-1];
                end
            end
        end
    endgenerate

    // Delayed copy of the synchronised level used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_o <= '0;
        else        prev_o <= chain_q[STAGES-1];
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/intc_bank.sv
// One register bank: enable, trigger mode, polarity, edge latches and
// the masked status that drives this bank's interrupt output.
// Assumes src_i/prev_i are already synchronised and the write strobes
// are decoded one-hot per register.
module intc_bank
    import intc_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] src_i,
    input  logic [NUM_LINES-1:0] prev_i,
    input  bank_we_t             we_i,
    input  logic [NUM_LINES-1:0] wdata_i,
    output logic [NUM_LINES-1:0] en_o,
    output logic [NUM_LINES-1:0] mode_o,
    output logic [NUM_LINES-1:0] pol_o,
    output logic [NUM_LINES-1:0] status_o,
    output logic                 irq_o
);

    logic [NUM_LINES-1:0] en_q, mode_q, pol_q, latch_q;
    logic [NUM_LINES-1:0] rise_w, fall_w, evt_w, clr_w, level_w, pend_w;

    // Configuration registers, written whole-word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mode_q <= '0;
            pol_q  <= '0;
        end else begin
            if (we_i.en)   en_q   <= wdata_i;
            if (we_i.mode) mode_q <= wdata_i;
            if (we_i.pol)  pol_q  <= wdata_i;
        end
    end

    // Edge event detection for lines in edge mode
    always_comb begin
        rise_w = src_i & ~prev_i;
        fall_w = ~src_i & prev_i;
        evt_w  = mode_q & ((pol_q & rise_w) | (~pol_q & fall_w));
        clr_w  = we_i.clr ? wdata_i : '0;
    end

    // Sticky edge latches; a new event beats a simultaneous clear
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= (latch_q & ~clr_w) | evt_w;
    end

    // Pending vector and masked status
    always_comb begin
        level_w  = pol_q ^ src_i;
        pend_w   = (~mode_q & level_w) | (mode_q & latch_q);
        status_o = en_q & pend_w;
    end

    assign irq_o  = |status_o;
    assign en_o   = en_q;
    assign mode_o = mode_q;
    assign pol_o  = pol_q;

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_w & ~evt_w)) |=> ((latch_q & $past(clr_w & ~evt_w)) == '0)); // R8

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_w) |=> ((latch_q & $past(evt_w)) == $past(evt_w))); // R9

    AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|(latch_q & ~clr_w)) |=> ((latch_q & $past(latch_q & ~clr_w)) == $past(latch_q & ~clr_w))); // R7

    AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i.en && wdata_i == '0) |=> !irq_o); // R5

endmodule

// File: rtl/dual_intc.sv
// Dual-bank interrupt controller top level.
// Synchronises the raw lines once, feeds both banks, decodes the
// register port and multiplexes read data. Assumes reg_addr and
// reg_wdata are stable while reg_wr is high.
module dual_intc
    import intc_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 6,
    parameter int SYNC_LEN  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [NUM_LINES-1:0] reg_wdata,
    output logic [NUM_LINES-1:0] reg_rdata,
    output logic                 norm_irq,
    output logic                 fast_irq
);

    localparam int NUM_BANKS = 2;
    localparam int BANK_BIT  = ADDR_W - 1;

    logic [NUM_LINES-1:0] src_w, prev_w;
    logic [NUM_LINES-1:0] en_w   [NUM_BANKS];
    logic [NUM_LINES-1:0] mode_w [NUM_BANKS];
    logic [NUM_LINES-1:0] pol_w  [NUM_BANKS];
    logic [NUM_LINES-1:0] stat_w [NUM_BANKS];
    logic                 irq_w  [NUM_BANKS];
    bank_we_t             we_w   [NUM_BANKS];
    logic                 aligned_w;
    reg_idx_e             idx_w;

    assign aligned_w = (reg_addr[1:0] == 2'b00);
    assign idx_w     = reg_idx_e'(reg_addr[4:2]);

    intc_sync #(.NUM_LINES(NUM_LINES), .STAGES(SYNC_LEN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_lines),
        .sync_o  (src_w),
        .prev_o  (prev_w)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            // Write strobe decode for this bank
            always_comb begin
                we_w[b] = '0;
                if (reg_wr && aligned_w && (reg_addr[BANK_BIT] == b[0])) begin
                    we_w[b].en   = (idx_w == RIDX_EN);
                    we_w[b].clr  = (idx_w == RIDX_CLR);
                    we_w[b].mode = (idx_w == RIDX_MODE);
                    we_w[b].pol  = (idx_w == RIDX_POL);
                end
            end

            intc_bank #(.NUM_LINES(NUM_LINES)) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .src_i    (src_w),
                .prev_i   (prev_w),
                .we_i     (we_w[b]),
                .wdata_i  (reg_wdata),
                .en_o     (en_w[b]),
                .mode_o   (mode_w[b]),
                .pol_o    (pol_w[b]),
                .status_o (stat_w[b]),
                .irq_o    (irq_w[b])
            );
        end
    endgenerate

    // Read data multiplexer; unmapped and clear reads return zero
    always_comb begin
        logic bsel;
        bsel      = reg_addr[BANK_BIT];
        reg_rdata = '0;
        if (aligned_w) begin
            case (idx_w)
                RIDX_SRC:  reg_rdata = src_w;
                RIDX_EN:   reg_rdata = en_w[bsel];
                RIDX_MODE: reg_rdata = mode_w[bsel];
                RIDX_POL:  reg_rdata = pol_w[bsel];
                RIDX_STAT: reg_rdata = stat_w[bsel];
                default:   reg_rdata = '0;
            endcase
        end
    end

    assign norm_irq = irq_w[0];
    assign fast_irq = irq_w[1];

    AST_LEVEL_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(en_w[0] & ~mode_w[0] & ~pol_w[0] & src_w)) |-> norm_irq); // R6

    AST_FAST_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (|(en_w[1] & ~mode_w[1] & pol_w[1] & ~src_w)) |-> fast_irq); // R10

endmodule

// File: tb/dual_intc_bench.sv
`timescale 1ns/100ps
module dual_intc_bench;

    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_lines = '0;
    logic         reg_wr = 1'b0;
    logic [5:0]   reg_addr = '0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         norm_irq, fast_irq;

    int checks = 0;
    int fails  = 0;

    // Bench model of each bank
    logic [N-1:0] m_en [2];
    logic [N-1:0] m_mode [2];
    logic [N-1:0] m_pol [2];
    logic [N-1:0] m_lat [2];
    logic [N-1:0] m_lvl;

    always #2 clk = ~clk;

    dual_intc u_dual_intc (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .norm_irq(norm_irq), .fast_irq(fast_irq)
    );

    function automatic logic [N-1:0] exp_status(int b);
        logic [N-1:0] pend;
        pend = (~m_mode[b] & (m_pol[b] ^ m_lvl)) | (m_mode[b] & m_lat[b]);
        return m_en[b] & pend;
    endfunction

    function automatic logic [5:0] addr_of(int b, int idx);
        return 6'((b * 32) + (idx * 4));
    endfunction

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [N-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [N-1:0] v);
        @(negedge clk);
        reg_addr = a;
        #0.5 v = reg_rdata;
    endtask

    task automatic set_cfg(int b, int idx, logic [N-1:0] d);
        wr(addr_of(b, idx), d);
        if (idx == 1) m_en[b] = d;
        if (idx == 3) m_mode[b] = d;
        if (idx == 4) m_pol[b] = d;
        if (idx == 2) m_lat[b] = m_lat[b] & ~d;
    endtask

    // Change the lines, update the model, then let them settle
    task automatic move_lines(logic [N-1:0] v);
        for (int b = 0; b < 2; b++)
            m_lat[b] |= m_mode[b] & ((m_pol[b] & v & ~m_lvl) | (~m_pol[b] & ~v & m_lvl));
        m_lvl = v;
        @(negedge clk);
        irq_lines = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_all(string tag);
        logic [N-1:0] v;
        for (int b = 0; b < 2; b++) begin
            rd(addr_of(b, 5), v);
            check({tag, " status"}, v, exp_status(b));
            check({tag, " irq"}, {31'd0, (b == 0) ? norm_irq : fast_irq},
                  {31'd0, |exp_status(b)});
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [N-1:0] v;
        int unused_seed;
        unused_seed = $urandom(32'd2024);
        for (int b = 0; b < 2; b++) begin
            m_en[b] = '0; m_mode[b] = '0; m_pol[b] = '0; m_lat[b] = '0;
        end
        m_lvl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state of every register and output
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 8; i++) begin
                rd(addr_of(b, i), v);
                check("R1 reset read", v, '0);
            end
        check("R1 outputs", {30'd0, norm_irq, fast_irq}, '0);

        // R3: two-edge source delay, and writes are ignored
        reg_addr = addr_of(0, 0);
        @(negedge clk); irq_lines = 32'h0000_00A5;
        @(posedge clk); #0.5 check("R3 src after 1 edge", reg_rdata, '0);
        @(posedge clk); #0.5 check("R3 src after 2 edges", reg_rdata, 32'h0000_00A5);
        m_lvl = 32'h0000_00A5;
        wr(addr_of(0, 0), 32'hFFFF_0000);
        rd(addr_of(0, 0), v);
        check("R3 src write ignored", v, 32'h0000_00A5);
        rd(addr_of(1, 0), v);
        check("R2 src visible in fast bank", v, 32'h0000_00A5);

        // R4: config read-back; R2 misaligned and unmapped read zero
        set_cfg(1, 4, 32'h1234_5678);
        rd(addr_of(1, 4), v);
        check("R4 polarity readback", v, 32'h1234_5678);
        rd(addr_of(0, 4), v);
        check("R10 bank independence", v, '0);
        rd(addr_of(1, 4) + 6'd1, v);
        check("R2 misaligned read", v, '0);
        rd(addr_of(0, 7), v);
        check("R2 unmapped read", v, '0);
        rd(addr_of(0, 2), v);
        check("R2 clear reads zero", v, '0);
        set_cfg(1, 4, '0);

        // R6: level high/low on the normal bank
        set_cfg(0, 1, 32'h0000_000F);
        check_all("R6 level high");
        set_cfg(0, 4, 32'h0000_000F);
        check_all("R6 level low");
        // R5: zero mask drops the output
        set_cfg(0, 4, '0);
        set_cfg(0, 1, '0);
        check("R5 mask zero irq", {31'd0, norm_irq}, '0);

        // R7/R8/R9: directed edge sequence on line 3 in the normal bank
        move_lines('0);
        set_cfg(0, 3, 32'h0000_0008);
        set_cfg(0, 4, 32'h0000_0008);
        set_cfg(0, 1, 32'h0000_0008);
        move_lines(32'h0000_0008);
        move_lines('0);
        check_all("R7 rising latched");
        set_cfg(0, 2, 32'hFFFF_FFF7);
        check_all("R8 zero bits no effect");
        // Rising edge coincides with a clear of the same bit
        @(negedge clk); irq_lines = 32'h0000_0008;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk); reg_wr = 1'b1; reg_addr = addr_of(0, 2); reg_wdata = 32'h0000_0008;
        @(negedge clk); reg_wr = 1'b0;
        m_lvl = 32'h0000_0008;
        repeat (3) @(negedge clk);
        rd(addr_of(0, 5), v);
        check("R9 edge beats clear", v, 32'h0000_0008);
        set_cfg(0, 2, 32'h0000_0008);
        check_all("R8 clear latch");
        set_cfg(0, 4, '0);
        move_lines('0);
        check_all("R7 falling latched");

        // Constrained random phase over both banks
        for (int it = 0; it < 300; it++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 5) begin
                move_lines($urandom());
            end else if (op < 7) begin
                set_cfg($urandom_range(0, 1), 2, $urandom());
            end else begin
                set_cfg($urandom_range(0, 1), $urandom_range(1, 4), $urandom());
            end
            check_all("R10 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule